// File: doc/BRIEF.md
# Overlap-Safe Region Protection Checker

This block sits in front of a memory and decides whether each bus access may go through. Three programmable address windows each carry an inclusive lower and upper bound, an enable, separate read and write permits and an owner privilege level from 0 to 3, where 3 is the trusted level. Every access presents an address, a direction and the requester's privilege. One cycle later the block answers with grant or fault. On a fault it records the address and the direction.

Windows may overlap, and a trusted control bit picks how an overlap is settled. In first-match mode the lowest-numbered window that contains the address decides. In all-match mode every containing window must permit the access. The configuration write port checks each write against the window the write would produce. It refuses any write that would let a less privileged requester place a window over one owned by a more privileged level. It also refuses any change to a window whose owner outranks the writer. When the trusted overlap-block bit is set, it refuses every write that would make two enabled windows intersect. A refused write leaves all state unchanged, sets a sticky error bit and records the page that was targeted.

Top module: `mpu_overlap_guard`

## Requirements
- R1: Window r matches an address when its enable bit is 1 and lower <= address <= upper. Both bounds are inclusive. A window whose lower bound is above its upper bound matches nothing and never counts as intersecting another window.
- R2: A matching window allows an access only if the requester privilege is >= the window's owner and the window's permit for that direction is 1 (read permit for acc_write=0, write permit for acc_write=1).
- R3: With the mode bit at 0 (first-match), the access is granted exactly when the lowest-indexed matching window allows it.
- R4: With the mode bit at 1 (all-match), the access is granted only when every matching window allows it.
- R5: An access that matches no window is granted exactly when the default-allow bit is 1.
- R6: rsp_valid is high in the cycle after acc_valid. rsp_fault is high in that same cycle exactly when the answer is deny. A denied access loads its address into the fault-address register (read address 14) and its direction into bit 0 of the fault-type register (read address 15).
- R7: Configuration addresses are {page[1:0], field[1:0]}. Page 3 is the control page. Its field 0 holds {overlap-block bit 2, default-allow bit 1, mode bit 0}. A write to page 3 from any privilege below 3 changes nothing and is refused.
- R8: Pages 0 to 2 address windows 0 to 2. Field 0 is the lower bound, field 1 the upper bound, and field 2 the attributes {owner[4:3], write permit bit 2, read permit bit 1, enable bit 0}. Field 3 writes are ignored. A window write is refused when the writer's privilege is below the window's current owner, or when a field-2 write names an owner above the writer's privilege.
- R9: A window write is refused when the resulting enabled window would intersect another enabled window whose owner is above the writer's privilege. A refused write leaves every window unchanged.
- R10: With the overlap-block bit at 1, a window write is refused when the resulting enabled window would intersect any other enabled window. A write that produces no intersection is still accepted.
- R11: Any refused write sets the sticky error bit (status field 1 at read address 13, bit 0) and stores the refused page in bits 2:1. A privilege-3 write of 1 to status bit 0 clears the error bit and leaves the stored page unchanged.
- R12: After reset every register reads 0. All windows are disabled, the mode is first-match, and default-allow and overlap-block are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access request present |
| acc_ready | output | 1 | Always 1: one access accepted per cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_priv | input | 2 | Requester privilege, 3 is trusted |
| rsp_valid | output | 1 | Answer present, one cycle after the request |
| rsp_grant | output | 1 | Access allowed |
| rsp_fault | output | 1 | Access denied pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration address {page, field} |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_priv | input | 2 | Privilege of the configuration writer |
| rd_addr | input | 4 | Register read address, same map as cfg_addr |
| rd_data | output | ADDR_W | Register read data (combinational) |

## Verification
A bound or attribute that takes a refused write shows up in rd_data as soon as that window's address is selected. It also changes a grant for any access that lands in the altered span on the next request. An error bit that fails to set or clear shows at read address 13 in the cycle after the write. A wrong overlap resolution shows in rsp_grant one cycle after an access to a shared address. A missed fault capture shows at addresses 14 and 15 right after the denial. For these reasons a behavioural model is compared against every answer and against one register read in every cycle, with window spans drawn from a small address range so that overlaps happen often.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  localparam int unsigned NUM_WINDOWS = 3;
  localparam int unsigned PRIV_W      = 2;
  localparam logic [PRIV_W-1:0] PRIV_TRUSTED = 2'd3;

  typedef enum logic {
    RES_FIRST = 1'b0,
    RES_ALL   = 1'b1
  } res_mode_e;

  typedef struct packed {
    logic [PRIV_W-1:0] owner;
    logic              wr_ok;
    logic              rd_ok;
    logic              en;
  } win_attr_t;

  localparam int unsigned ATTR_W = $bits(win_attr_t);

  // inclusive containment; an inverted span never contains anything
  function automatic logic addr_within(logic [31:0] a, logic [31:0] lo, logic [31:0] hi);
    return (lo <= hi) && (lo <= a) && (a <= hi);
  endfunction

  // two well-formed inclusive spans share at least one address
  function automatic logic spans_touch(logic [31:0] lo_a, logic [31:0] hi_a,
                                       logic [31:0] lo_b, logic [31:0] hi_b);
    return (lo_a <= hi_a) && (lo_b <= hi_b) && (lo_a <= hi_b) && (lo_b <= hi_a);
  endfunction

endpackage

// File: rtl/mpu_window_match.sv
module mpu_window_match
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] lo_bound,
  input  logic [ADDR_W-1:0] hi_bound,
  input  win_attr_t         attr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [PRIV_W-1:0] acc_priv,
  output logic              hit,
  output logic              allow
);

  logic dir_ok;
  logic priv_ok;

  assign hit     = attr.en && addr_within(32'(acc_addr), 32'(lo_bound), 32'(hi_bound));
  assign dir_ok  = acc_write ? attr.wr_ok : attr.rd_ok;
  assign priv_ok = (acc_priv >= attr.owner);
  assign allow   = dir_ok && priv_ok;

endmodule

// File: rtl/mpu_access_judge.sv
module mpu_access_judge
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NWIN   = NUM_WINDOWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [NWIN-1:0]   hit,
  input  logic [NWIN-1:0]   allow,
  input  res_mode_e         mode,
  input  logic              dflt_allow,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] flt_addr,
  output logic              flt_write
);

  logic first_ok;
  logic all_ok;
  logic any_hit;
  logic verdict;
  logic deny_evt;

  always_comb begin
    first_ok = 1'b0;
    for (int i = int'(NWIN) - 1; i >= 0; i--) begin
      if (hit[i]) first_ok = allow[i];
    end
    all_ok  = &(~hit | allow);
    any_hit = |hit;
    if (!any_hit)              verdict = dflt_allow;
    else if (mode == RES_ALL)  verdict = all_ok;
    else                       verdict = first_ok;
  end

  assign deny_evt = acc_valid && !verdict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
      rsp_fault <= 1'b0;
      flt_addr  <= '0;
      flt_write <= 1'b0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_grant <= acc_valid && verdict;
      rsp_fault <= deny_evt;
      if (deny_evt) begin
        flt_addr  <= acc_addr;
        flt_write <= acc_write;
      end
    end
  end

  assert_answer_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  assert_no_spurious_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
  assert_fault_means_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && !rsp_grant));
  assert_deny_means_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_grant) |-> rsp_fault);
  assert_first_window_rules_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == RES_FIRST && hit[0]) |=> (rsp_grant == $past(allow[0])));
  assert_all_must_allow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && mode == RES_ALL && |(hit & ~allow)) |=> !rsp_grant);
  assert_miss_uses_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && hit == '0) |=> (rsp_grant == $past(dflt_allow)));
  assert_fault_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    deny_evt |=> (flt_addr == $past(acc_addr)));

endmodule

// File: rtl/mpu_cfg_guard.sv
module mpu_cfg_guard
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NWIN   = NUM_WINDOWS,
  localparam int unsigned PAGE_W = $clog2(NWIN + 1),
  localparam int unsigned CFG_AW = PAGE_W + 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [CFG_AW-1:0]           cfg_addr,
  input  logic [ADDR_W-1:0]           cfg_wdata,
  input  logic [PRIV_W-1:0]           cfg_priv,
  output logic [NWIN-1:0][ADDR_W-1:0] lo_q,
  output logic [NWIN-1:0][ADDR_W-1:0] hi_q,
  output win_attr_t [NWIN-1:0]        attr_q,
  output res_mode_e                   mode,
  output logic                        dflt_allow,
  output logic                        ovl_block,
  output logic                        err_flag,
  output logic [PAGE_W-1:0]           err_page
);

  logic [PAGE_W-1:0] page;
  logic [1:0]        fld;
  logic              is_ctrl;
  logic [PAGE_W-1:0] tgt;
  logic              trusted;
  logic [2:0]        ctrl_q;

  logic [ADDR_W-1:0] cand_lo;
  logic [ADDR_W-1:0] cand_hi;
  win_attr_t         cand_attr;
  logic              hi_clash;
  logic              any_clash;
  logic              owner_ok;
  logic              new_owner_ok;
  logic              win_field;
  logic              win_reject;
  logic              ctrl_reject;
  logic              wr_reject;
  logic              win_commit;
  logic              ctrl_commit;
  logic              err_clear;

  assign page      = cfg_addr[CFG_AW-1:2];
  assign fld       = cfg_addr[1:0];
  assign is_ctrl   = (int'(page) >= int'(NWIN));
  assign tgt       = is_ctrl ? '0 : page;
  assign trusted   = (cfg_priv == PRIV_TRUSTED);
  assign win_field = !is_ctrl && (fld != 2'd3);

  // window as it would look after this write
  always_comb begin
    cand_lo   = lo_q[tgt];
    cand_hi   = hi_q[tgt];
    cand_attr = attr_q[tgt];
    unique case (fld)
      2'd0:    cand_lo   = cfg_wdata;
      2'd1:    cand_hi   = cfg_wdata;
      2'd2:    cand_attr = win_attr_t'(cfg_wdata[ATTR_W-1:0]);
      default: ;
    endcase
  end

  always_comb begin
    hi_clash  = 1'b0;
    any_clash = 1'b0;
    for (int j = 0; j < int'(NWIN); j++) begin
      if (j != int'(tgt) && cand_attr.en && attr_q[j].en &&
          spans_touch(32'(cand_lo), 32'(cand_hi), 32'(lo_q[j]), 32'(hi_q[j]))) begin
        any_clash = 1'b1;
        if (attr_q[j].owner > cfg_priv) hi_clash = 1'b1;
      end
    end
  end

  assign owner_ok     = (cfg_priv >= attr_q[tgt].owner);
  assign new_owner_ok = (fld != 2'd2) || (cand_attr.owner <= cfg_priv);
  assign win_reject   = win_field &&
                        (!owner_ok || !new_owner_ok || hi_clash || (ovl_block && any_clash));
  assign ctrl_reject  = is_ctrl && !trusted;
  assign wr_reject    = cfg_we && (win_reject || ctrl_reject);
  assign win_commit   = cfg_we && win_field && !win_reject;
  assign ctrl_commit  = cfg_we && is_ctrl && trusted && (fld == 2'd0);
  assign err_clear    = cfg_we && is_ctrl && trusted && (fld == 2'd1) && cfg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      hi_q   <= '0;
      attr_q <= '0;
    end else if (win_commit) begin
      for (int r = 0; r < int'(NWIN); r++) begin
        if (r == int'(tgt)) begin
          lo_q[r]   <= cand_lo;
          hi_q[r]   <= cand_hi;
          attr_q[r] <= cand_attr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      err_flag <= 1'b0;
      err_page <= '0;
    end else begin
      if (ctrl_commit) ctrl_q <= cfg_wdata[2:0];
      if (wr_reject) begin
        err_flag <= 1'b1;
        err_page <= page;
      end else if (err_clear) begin
        err_flag <= 1'b0;
      end
    end
  end

  assign mode       = res_mode_e'(ctrl_q[0]);
  assign dflt_allow = ctrl_q[1];
  assign ovl_block  = ctrl_q[2];

  assert_ctrl_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && is_ctrl && !trusted) |=> $stable(ctrl_q));
  assert_reject_sets_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> (err_flag && err_page == $past(page)));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clear) |=> err_flag);

  for (genvar r = 0; r < int'(NWIN); r++) begin : g_win_chk
    assert_owner_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && int'(page) == r && cfg_priv < attr_q[r].owner)
      |=> ($stable(lo_q[r]) && $stable(hi_q[r]) && $stable(attr_q[r])));
    assert_reject_freezes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |=> ($stable(lo_q[r]) && $stable(hi_q[r]) && $stable(attr_q[r])));
  end

endmodule

// File: rtl/mpu_overlap_guard.sv
module mpu_overlap_guard
  import mpu_guard_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned NWIN   = NUM_WINDOWS,
  localparam int unsigned PAGE_W = $clog2(NWIN + 1),
  localparam int unsigned CFG_AW = PAGE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  input  logic [PRIV_W-1:0] acc_priv,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic              rsp_fault,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [PRIV_W-1:0] cfg_priv,
  input  logic [CFG_AW-1:0] rd_addr,
  output logic [ADDR_W-1:0] rd_data
);

  logic [NWIN-1:0][ADDR_W-1:0] lo_q;
  logic [NWIN-1:0][ADDR_W-1:0] hi_q;
  win_attr_t [NWIN-1:0]        attr_q;
  res_mode_e                   mode;
  logic                        dflt_allow;
  logic                        ovl_block;
  logic                        err_flag;
  logic [PAGE_W-1:0]           err_page;
  logic [NWIN-1:0]             hit;
  logic [NWIN-1:0]             allow;
  logic [ADDR_W-1:0]           flt_addr;
  logic                        flt_write;
  logic [PAGE_W-1:0]           rd_page;
  logic [1:0]                  rd_fld;
  logic [PAGE_W-1:0]           rd_win;

  assign acc_ready = 1'b1;

  mpu_cfg_guard #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_priv   (cfg_priv),
    .lo_q       (lo_q),
    .hi_q       (hi_q),
    .attr_q     (attr_q),
    .mode       (mode),
    .dflt_allow (dflt_allow),
    .ovl_block  (ovl_block),
    .err_flag   (err_flag),
    .err_page   (err_page)
  );

  for (genvar r = 0; r < int'(NWIN); r++) begin : g_win
    mpu_window_match #(.ADDR_W(ADDR_W)) u_match (
      .lo_bound  (lo_q[r]),
      .hi_bound  (hi_q[r]),
      .attr      (attr_q[r]),
      .acc_addr  (acc_addr),
      .acc_write (acc_write),
      .acc_priv  (acc_priv),
      .hit       (hit[r]),
      .allow     (allow[r])
    );
  end

  mpu_access_judge #(.ADDR_W(ADDR_W), .NWIN(NWIN)) u_judge (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .acc_write  (acc_write),
    .hit        (hit),
    .allow      (allow),
    .mode       (mode),
    .dflt_allow (dflt_allow),
    .rsp_valid  (rsp_valid),
    .rsp_grant  (rsp_grant),
    .rsp_fault  (rsp_fault),
    .flt_addr   (flt_addr),
    .flt_write  (flt_write)
  );

  assign rd_page = rd_addr[CFG_AW-1:2];
  assign rd_fld  = rd_addr[1:0];
  assign rd_win  = (int'(rd_page) < int'(NWIN)) ? rd_page : '0;

  always_comb begin
    rd_data = '0;
    if (int'(rd_page) < int'(NWIN)) begin
      unique case (rd_fld)
        2'd0:    rd_data = lo_q[rd_win];
        2'd1:    rd_data = hi_q[rd_win];
        2'd2:    rd_data = ADDR_W'(attr_q[rd_win]);
        default: rd_data = '0;
      endcase
    end else begin
      unique case (rd_fld)
        2'd0:    rd_data = ADDR_W'({ovl_block, dflt_allow, mode});
        2'd1:    rd_data = ADDR_W'({err_page, err_flag});
        2'd2:    rd_data = flt_addr;
        default: rd_data = ADDR_W'(flt_write);
      endcase
    end
  end

endmodule

// File: tb/sim_mpu_overlap_guard.sv
`timescale 1ns/1ps
module sim_mpu_overlap_guard;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid;
  logic        acc_ready;
  logic [15:0] acc_addr;
  logic        acc_write;
  logic [1:0]  acc_priv;
  logic        rsp_valid, rsp_grant, rsp_fault;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic [1:0]  cfg_priv;
  logic [3:0]  rd_addr;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int last_rd;

  // behavioural reference state
  int mlo[3], mhi[3], mown[3];
  bit men[3], mrd[3], mwr[3];
  bit mmode, mdflt, mblk, merr;
  int merrpg, mfa;
  bit mfw;
  bit e_valid, e_grant, e_fault;
  string e_tag = "R12";

  always #2.5 clk = ~clk;

  mpu_overlap_guard u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_write(acc_write), .acc_priv(acc_priv),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_fault(rsp_fault),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_priv(cfg_priv),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic m_reset();
    for (int r = 0; r < 3; r++) begin
      mlo[r] = 0; mhi[r] = 0; mown[r] = 0; men[r] = 0; mrd[r] = 0; mwr[r] = 0;
    end
    mmode = 0; mdflt = 0; mblk = 0; merr = 0; merrpg = 0; mfa = 0; mfw = 0;
    e_valid = 0; e_grant = 0; e_fault = 0; e_tag = "R12";
  endtask

  function automatic int m_read(int a);
    int pg = a / 4;
    int f  = a % 4;
    if (pg < 3) begin
      if (f == 0) return mlo[pg];
      if (f == 1) return mhi[pg];
      if (f == 2) return mown[pg] * 8 + int'(mwr[pg]) * 4 + int'(mrd[pg]) * 2 + int'(men[pg]);
      return 0;
    end
    if (f == 0) return int'(mblk) * 4 + int'(mdflt) * 2 + int'(mmode);
    if (f == 1) return merrpg * 2 + int'(merr);
    if (f == 2) return mfa;
    return int'(mfw);
  endfunction

  function automatic bit m_allows(int r, bit w, int p);
    return (p >= mown[r]) && (w ? mwr[r] : mrd[r]);
  endfunction

  task automatic m_access(int a, bit w, int p);
    int hits[$];
    bit ok;
    for (int r = 0; r < 3; r++)
      if (men[r] && mlo[r] <= a && a <= mhi[r]) hits.push_back(r);
    if (hits.size() == 0) begin
      ok = mdflt; e_tag = "R5";
    end else if (!mmode) begin
      ok = m_allows(hits[0], w, p); e_tag = (hits.size() > 1) ? "R3" : "R2";
    end else begin
      ok = 1;
      foreach (hits[k]) if (!m_allows(hits[k], w, p)) ok = 0;
      e_tag = (hits.size() > 1) ? "R4" : "R2";
    end
    e_valid = 1; e_grant = ok; e_fault = !ok;
    if (!ok) begin mfa = a; mfw = w; end
  endtask

  task automatic m_cfg(int a, int d, int p);
    int pg = a / 4;
    int f  = a % 4;
    int nlo, nhi, nown;
    bit nen, nrd, nwr, rej, hi, any;
    rej = 0;
    if (pg == 3) begin
      if (p != 3) rej = 1;
      else if (f == 0) begin mmode = d[0]; mdflt = d[1]; mblk = d[2]; end
      else if (f == 1 && d[0]) merr = 0;
    end else if (f != 3) begin
      nlo = mlo[pg]; nhi = mhi[pg]; nown = mown[pg];
      nen = men[pg]; nrd = mrd[pg]; nwr = mwr[pg];
      if (f == 0) nlo = d;
      if (f == 1) nhi = d;
      if (f == 2) begin nown = (d / 8) % 4; nwr = d[2]; nrd = d[1]; nen = d[0]; end
      if (p < mown[pg]) rej = 1;
      if (f == 2 && nown > p) rej = 1;
      hi = 0; any = 0;
      for (int j = 0; j < 3; j++) begin
        if (j != pg && nen && men[j] && nlo <= nhi && mlo[j] <= mhi[j] &&
            nlo <= mhi[j] && mlo[j] <= nhi) begin
          any = 1;
          if (mown[j] > p) hi = 1;
        end
      end
      if (hi || (mblk && any)) rej = 1;
      if (!rej) begin
        mlo[pg] = nlo; mhi[pg] = nhi; mown[pg] = nown;
        men[pg] = nen; mrd[pg] = nrd; mwr[pg] = nwr;
      end
    end
    if (rej) begin merr = 1; merrpg = pg; end
  endtask

  // one clock: drive, check register read, edge, model, check answer
  task automatic step(bit av, int aa, bit aw, int ap, bit cw, int ca, int cd, int cp, int ra);
    acc_valid = av; acc_addr = 16'(aa); acc_write = aw; acc_priv = 2'(ap);
    cfg_we = cw; cfg_addr = 4'(ca); cfg_wdata = 16'(cd); cfg_priv = 2'(cp);
    rd_addr = 4'(ra);
    #1;
    last_rd = int'(rd_data);
    chk((ra < 12) ? "R8" : "R11", last_rd, m_read(ra));
    @(posedge clk);
    if (av) m_access(aa, aw, ap);
    else begin e_valid = 0; e_grant = 0; e_fault = 0; e_tag = "R6"; end
    if (cw) m_cfg(ca, cd, cp);
    @(negedge clk);
    chk("R6", int'(rsp_valid), int'(e_valid));
    chk(e_tag, int'(rsp_grant), int'(e_grant));
    chk("R6", int'(rsp_fault), int'(e_fault));
  endtask

  task automatic acc(int a, bit w, int p);
    step(1, a, w, p, 0, 0, 0, 0, 0);
  endtask
  task automatic cfg(int a, int d, int p);
    step(0, 0, 0, 0, 1, a, d, p, 0);
  endtask
  task automatic peek(int a);
    step(0, 0, 0, 0, 0, 0, 0, 0, a);
  endtask

  initial begin
    rst_n = 0; acc_valid = 0; acc_addr = 0; acc_write = 0; acc_priv = 0;
    cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; cfg_priv = 0; rd_addr = 0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    for (int a = 0; a < 16; a++) begin
      peek(a); chk("R12", last_rd, 0);
    end

    // window 0: [0x10,0x1F] read-only owner 1; window 1: [0x18,0x2F] rw owner 1
    cfg(0, 'h10, 3); cfg(1, 'h1F, 3); cfg(2, 'h0B, 3);
    cfg(4, 'h18, 3); cfg(5, 'h2F, 3); cfg(6, 'h0F, 3);
    acc('h18, 1, 1); chk("R3", rsp_grant, 0); chk("R3", rsp_fault, 1);
    acc('h18, 0, 1); chk("R3", rsp_grant, 1);
    acc('h20, 1, 1); chk("R2", rsp_grant, 1);
    acc('h20, 1, 0); chk("R2", rsp_grant, 0);
    acc('h10, 0, 1); chk("R1", rsp_grant, 1);
    acc('h2F, 1, 1); chk("R1", rsp_grant, 1);
    acc('h30, 0, 1); chk("R5", rsp_grant, 0);
    cfg(12, 2, 3);
    acc('h30, 0, 0); chk("R5", rsp_grant, 1);

    // all-match mode
    cfg(12, 3, 3);
    acc('h18, 0, 1); chk("R4", rsp_grant, 1);
    acc('h18, 1, 1); chk("R4", rsp_grant, 0);
    peek(14); chk("R6", last_rd, 'h18);
    peek(15); chk("R6", last_rd, 1);

    // untrusted control write
    cfg(12, 0, 1);
    peek(12); chk("R7", last_rd, 3);
    peek(13); chk("R11", last_rd, 7);
    cfg(13, 1, 3);
    peek(13); chk("R11", last_rd, 6);

    // window 2 owned by trusted level
    cfg(8, 'h40, 3); cfg(9, 'h4F, 3); cfg(10, 'h1B, 3);
    cfg(1, 'h45, 1);
    peek(1); chk("R9", last_rd, 'h1F);
    peek(13); chk("R9", last_rd, 1);
    cfg(0, 'h12, 0);
    peek(0); chk("R8", last_rd, 'h10);
    cfg(2, 'h13, 1);
    peek(2); chk("R8", last_rd, 'h0B);
    cfg(13, 1, 3);

    // overlap blocking
    cfg(12, 7, 3);
    cfg(4, 'h12, 3);
    peek(4); chk("R10", last_rd, 'h18);
    peek(13); chk("R10", last_rd, 3);
    cfg(9, 'h50, 3);
    peek(9); chk("R10", last_rd, 'h50);
    cfg(8, 'h60, 3);
    acc('h48, 1, 3); chk("R1", rsp_grant, 1);

    // mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int f;
      f = $urandom_range(0, 3);
      step(1'($urandom_range(0, 1)), $urandom_range(0, 127), 1'($urandom_range(0, 1)),
           $urandom_range(0, 3), ($urandom_range(0, 3) == 0), $urandom_range(0, 15),
           (f == 0) ? $urandom_range(0, 31) : $urandom_range(0, 127),
           $urandom_range(0, 3), $urandom_range(0, 15));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R6: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule